// File: doc/BRIEF.md
# Power-on strap capture and frequency-row selector

This block sits between the reset circuitry of a clock generator and its frequency synthesizer. At power-on it samples a set of configuration straps (a 4-bit frequency-row index, a pin-function mode bit and a CPU supply-voltage select bit) from pins that afterwards carry clock outputs. It samples them once and holds them until the next power-on reset. The held values are exposed for register readback and as status flags.

The active frequency row comes from the held strap index or from select bits in a software control byte. Bit 3 of that byte chooses the source. The chosen row passes through a stability filter. A new selection reaches the synthesizer only after it has been seen on a set number of consecutive reference clock edges, so a short disturbance on the select path never moves the output frequency. The filtered row is decoded into an opaque 36-bit frequency code word. This word carries CPU, memory and PCI rates in units of 0.1 MHz. The decode has one source-dependent entry: row 2 reports a different memory rate when software selected it.

Top module: `fsel_ctrl`

## Requirements
- R1: While `por_n` is low, every held strap reads 1 (`rb_*`, `mode_flag` and `cpu_vdd_25` all 1), `sel_idx` is 4'b1111 and `sel_from_sw` is 0.
- R2: On the first rising `clk` edge with `por_n` high, the levels on `pin_fs`, `pin_mode` and `pin_vsel` are captured and appear on the held outputs right after that edge.
- R3: After the capture, later changes on the strap pins have no effect on any held output until `por_n` goes low again. A fresh power-on reset captures anew.
- R4: `cfg_sel_byte[3]` = 0 selects the held strap index as the row source, and 1 selects the software index. `sel_from_sw` reports the source behind `sel_idx`.
- R5: The software index is {`cfg_sel_byte[2]`, `cfg_sel_byte[6:4]`}, with bit 2 as the most significant bit. The other byte bits are ignored.
- R6: Readback bits mirror the held straps as follows: `rb_r1_b7` = FS bit 2, `rb_r3_b6` = FS bit 0, `rb_r4_b3` = FS bit 1, `rb_r4_b1` = FS bit 3.
- R7: `cpu_vdd_25` is the held supply-select strap. 1 means a 2.5 V CPU supply and 0 means 3.3 V. `mode_flag` is the held mode strap.
- R8: A new (source, index) pair reaches `sel_idx`/`sel_from_sw` on the STABLE_CYC-th consecutive rising edge that samples it (default 2). Before that, the previous value is held.
- R9: A selection that lasts fewer than STABLE_CYC edges never appears on `sel_idx`.
- R10: `freq_code` = {CPU[35:24], memory[23:12], PCI[11:0]} in 0.1 MHz units, for rows 0..15: 668/1002/334, 1002/1002/334, 833/833/332, 1336/1002/334, 750/750/375, 1002/1336/334, 1002/1503/334, 1336/1336/334, 668/668/334, 970/970/323, 970/1293/323, 952/952/317, 1400/1400/350, 1120/1120/373, 962/962/321, 1660/1660/333.
- R11: Row 2 reports memory code 1249 instead of 833 when `sel_from_sw` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_fs | input | 4 | Frequency-index strap levels |
| pin_mode | input | 1 | Pin-function mode strap level |
| pin_vsel | input | 1 | CPU supply-select strap level |
| cfg_sel_byte | input | 8 | Software frequency control byte |
| sel_idx | output | 4 | Filtered active row index |
| sel_from_sw | output | 1 | Active row came from software |
| mode_flag | output | 1 | Held mode strap |
| cpu_vdd_25 | output | 1 | Held supply select (1 = 2.5 V) |
| rb_r1_b7 | output | 1 | Readback of held FS bit 2 |
| rb_r3_b6 | output | 1 | Readback of held FS bit 0 |
| rb_r4_b3 | output | 1 | Readback of held FS bit 1 |
| rb_r4_b1 | output | 1 | Readback of held FS bit 3 |
| freq_code | output | 36 | Decoded frequency code word |

## Verification
The bench moves the strap pins after capture and checks that nothing held follows them. A design that recaptures continuously would track the new pins. It toggles power-on reset a second time with different straps, which catches a capture that happens only once per simulation. It times software selection changes edge by edge and injects a one-cycle glitch, exposing a filter that is too short or off by one edge. It sweeps every software index to catch a swapped select bit. It selects row 2 from both sources, which exposes a decoder that ignores the source bit.

// File: rtl/fsel_pkg.sv
package fsel_pkg;

    localparam int IDX_W  = 4;
    localparam int CODE_W = 12;
    localparam int WORD_W = 3 * CODE_W;

    typedef logic [IDX_W-1:0]  idx_t;
    typedef logic [WORD_W-1:0] fword_t;

    // Selection key: source flag above the row index
    typedef struct packed {
        logic src_sw;
        idx_t idx;
    } sel_key_t;

    localparam int KEY_W = $bits(sel_key_t);

    function automatic fword_t pack3(input int cpu, input int mem, input int pci);
        return {CODE_W'(cpu), CODE_W'(mem), CODE_W'(pci)};
    endfunction

    // Frequency rows, 0.1 MHz units
    function automatic fword_t row_code(input idx_t idx, input logic from_sw);
        fword_t w;
        case (idx)
            4'd0:  w = pack3(668, 1002, 334);
            4'd1:  w = pack3(1002, 1002, 334);
            4'd2:  w = from_sw ? pack3(833, 1249, 332) : pack3(833, 833, 332);
            4'd3:  w = pack3(1336, 1002, 334);
            4'd4:  w = pack3(750, 750, 375);
            4'd5:  w = pack3(1002, 1336, 334);
            4'd6:  w = pack3(1002, 1503, 334);
            4'd7:  w = pack3(1336, 1336, 334);
            4'd8:  w = pack3(668, 668, 334);
            4'd9:  w = pack3(970, 970, 323);
            4'd10: w = pack3(970, 1293, 323);
            4'd11: w = pack3(952, 952, 317);
            4'd12: w = pack3(1400, 1400, 350);
            4'd13: w = pack3(1120, 1120, 373);
            4'd14: w = pack3(962, 962, 321);
            default: w = pack3(1660, 1660, 333);
        endcase
        return w;
    endfunction

endpackage

// File: rtl/fsel_strap_latch.sv
module fsel_strap_latch #(
    parameter int FS_W = 4
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic [FS_W-1:0] pin_fs,
    input  logic            pin_mode,
    input  logic            pin_vsel,
    output logic [FS_W-1:0] fs_held,
    output logic            mode_held,
    output logic            vsel_held
);

    typedef struct packed {
        logic            done;
        logic [FS_W-1:0] fs;
        logic            mode;
        logic            vsel;
    } strap_st_t;

    strap_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.done) begin
            st_d.done = 1'b1;
            st_d.fs   = pin_fs;
            st_d.mode = pin_mode;
            st_d.vsel = pin_vsel;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{done: 1'b0, fs: '1, mode: 1'b1, vsel: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign fs_held   = st_q.fs;
    assign mode_held = st_q.mode;
    assign vsel_held = st_q.vsel;

    // R2: the first edge out of reset loads the pin levels
    assert_capture_first_edge_R2: assert property (@(posedge clk) disable iff (!por_n)
        !st_q.done |=> (st_q.done && st_q.fs == $past(pin_fs)
                        && st_q.mode == $past(pin_mode) && st_q.vsel == $past(pin_vsel)));

    // R3: once captured, the straps never move
    assert_no_recapture_R3: assert property (@(posedge clk) disable iff (!por_n)
        st_q.done |=> ($stable(st_q.fs) && $stable(st_q.mode) && $stable(st_q.vsel)));

endmodule

// File: rtl/fsel_filter.sv
module fsel_filter #(
    parameter int               KEY_W      = 5,
    parameter int               STABLE_CYC = 2,
    parameter logic [KEY_W-1:0] RST_KEY    = '1
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic [KEY_W-1:0] key_raw,
    output logic [KEY_W-1:0] key_held
);

    localparam int RUN_W = $clog2(STABLE_CYC + 1);
    localparam logic [RUN_W-1:0] RUN_MAX = RUN_W'(STABLE_CYC);

    typedef struct packed {
        logic [KEY_W-1:0] cand;
        logic [RUN_W-1:0] run;
        logic [KEY_W-1:0] held;
    } flt_st_t;

    flt_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.cand = key_raw;
        if (key_raw == st_q.cand) begin
            if (st_q.run < RUN_MAX) begin
                st_d.run = st_q.run + RUN_W'(1);
            end
        end else begin
            st_d.run = RUN_W'(1);
        end
        if (st_d.run == RUN_MAX) begin
            st_d.held = key_raw;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            st_q <= '{cand: RST_KEY, run: '0, held: RST_KEY};
        end else begin
            st_q <= st_d;
        end
    end

    assign key_held = st_q.held;

    // R8: a saturated run means the output already shows the candidate
    assert_settled_matches_R8: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.run == RUN_MAX) |-> (st_q.held == st_q.cand));

    generate
        if (STABLE_CYC > 1) begin : g_glitch_chk
            // R9: a freshly changed selection cannot move the output
            assert_glitch_blocked_R9: assert property (@(posedge clk) disable iff (!por_n)
                (key_raw != st_q.cand) |=> $stable(st_q.held));
        end
    endgenerate

endmodule

// File: rtl/fsel_decode.sv
module fsel_decode
    import fsel_pkg::*;
(
    input  sel_key_t key,
    output fword_t   code
);

    always_comb begin
        code = row_code(key.idx, key.src_sw);
    end

endmodule

// File: rtl/fsel_ctrl.sv
module fsel_ctrl
    import fsel_pkg::*;
#(
    parameter int STABLE_CYC = 2
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic [IDX_W-1:0]  pin_fs,
    input  logic              pin_mode,
    input  logic              pin_vsel,
    input  logic [7:0]        cfg_sel_byte,
    output logic [IDX_W-1:0]  sel_idx,
    output logic              sel_from_sw,
    output logic              mode_flag,
    output logic              cpu_vdd_25,
    output logic              rb_r1_b7,
    output logic              rb_r3_b6,
    output logic              rb_r4_b3,
    output logic              rb_r4_b1,
    output logic [WORD_W-1:0] freq_code
);

    localparam sel_key_t RST_KEY = '{src_sw: 1'b0, idx: '1};

    idx_t     fs_held;
    sel_key_t key_raw;
    sel_key_t key_held;
    logic     unused_cfg_bits;

    fsel_strap_latch #(.FS_W(IDX_W)) i_latch (
        .clk       (clk),
        .por_n     (por_n),
        .pin_fs    (pin_fs),
        .pin_mode  (pin_mode),
        .pin_vsel  (pin_vsel),
        .fs_held   (fs_held),
        .mode_held (mode_flag),
        .vsel_held (cpu_vdd_25)
    );

    // Source mux: byte bit 3 picks software bits {b2, b6:b4}
    always_comb begin
        key_raw.src_sw = cfg_sel_byte[3];
        if (cfg_sel_byte[3]) begin
            key_raw.idx = {cfg_sel_byte[2], cfg_sel_byte[6:4]};
        end else begin
            key_raw.idx = fs_held;
        end
    end

    assign unused_cfg_bits = ^{cfg_sel_byte[7], cfg_sel_byte[1:0]};

    fsel_filter #(
        .KEY_W      (KEY_W),
        .STABLE_CYC (STABLE_CYC),
        .RST_KEY    (RST_KEY)
    ) i_filter (
        .clk      (clk),
        .por_n    (por_n),
        .key_raw  (key_raw),
        .key_held (key_held)
    );

    fsel_decode i_decode (
        .key  (key_held),
        .code (freq_code)
    );

    assign sel_idx     = key_held.idx;
    assign sel_from_sw = key_held.src_sw;

    // R6: scattered readback positions
    assign rb_r1_b7 = fs_held[2];
    assign rb_r3_b6 = fs_held[0];
    assign rb_r4_b3 = fs_held[1];
    assign rb_r4_b1 = fs_held[3];

    // R10: every row carries a non-zero CPU rate
    always_comb begin
        if (por_n) begin
            assert_cpu_code_nonzero_R10: assert (freq_code[WORD_W-1 -: CODE_W] != '0);
        end
    end

endmodule

// File: tb/test_fsel_ctrl.sv
module test_fsel_ctrl;

    localparam int STABLE = 2;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic [3:0]  pin_fs = 4'b0101;
    logic        pin_mode = 1'b0;
    logic        pin_vsel = 1'b0;
    logic [7:0]  cfg_sel_byte = 8'h00;
    logic [3:0]  sel_idx;
    logic        sel_from_sw, mode_flag, cpu_vdd_25;
    logic        rb_r1_b7, rb_r3_b6, rb_r4_b3, rb_r4_b1;
    logic [35:0] freq_code;

    int n_vec = 0;
    int n_bad = 0;
    bit running = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fsel_ctrl #(.STABLE_CYC(STABLE)) i_fsel_ctrl (
        .clk(clk), .por_n(por_n), .pin_fs(pin_fs), .pin_mode(pin_mode),
        .pin_vsel(pin_vsel), .cfg_sel_byte(cfg_sel_byte), .sel_idx(sel_idx),
        .sel_from_sw(sel_from_sw), .mode_flag(mode_flag), .cpu_vdd_25(cpu_vdd_25),
        .rb_r1_b7(rb_r1_b7), .rb_r3_b6(rb_r3_b6), .rb_r4_b3(rb_r4_b3),
        .rb_r4_b1(rb_r4_b1), .freq_code(freq_code)
    );

    // Row rates from the requirement table (0.1 MHz)
    int cpu_t [16] = '{668, 1002, 833, 1336, 750, 1002, 1002, 1336,
                       668, 970, 970, 952, 1400, 1120, 962, 1660};
    int mem_t [16] = '{1002, 1002, 833, 1002, 750, 1336, 1503, 1336,
                       668, 970, 1293, 952, 1400, 1120, 962, 1660};
    int pci_t [16] = '{334, 334, 332, 334, 375, 334, 334, 334,
                       334, 323, 323, 317, 350, 373, 321, 333};

    // Behavioural reference
    int m_fs, m_mode, m_vsel, m_held;
    bit m_done;
    int hist[$];

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_fs = 15; m_mode = 1; m_vsel = 1; m_done = 0; m_held = 15;
            hist.delete();
        end else begin
            int raw;
            bit same;
            raw = cfg_sel_byte[3] ? (16 + 8 * cfg_sel_byte[2] + cfg_sel_byte[6:4]) : m_fs;
            if (!m_done) begin
                m_fs = pin_fs; m_mode = pin_mode; m_vsel = pin_vsel; m_done = 1;
            end
            hist.push_back(raw);
            if (hist.size() > STABLE) void'(hist.pop_front());
            same = (hist.size() == STABLE);
            foreach (hist[k]) if (hist[k] != raw) same = 0;
            if (same) m_held = raw;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int mem_exp(input int key);
        if (key == 18) return 1249;
        return mem_t[key % 16];
    endfunction

    // Per-clock comparison with the reference
    always @(negedge clk) begin
        if (running) begin
            chk("R2/R3 fs", {rb_r4_b1, rb_r1_b7, rb_r4_b3, rb_r3_b6}, m_fs);
            chk("R7 mode", mode_flag, m_mode);
            chk("R7 vdd", cpu_vdd_25, m_vsel);
            chk("R8 key", 16 * sel_from_sw + sel_idx, m_held);
            chk("R10 cpu", freq_code[35:24], cpu_t[m_held % 16]);
            chk("R10/R11 mem", freq_code[23:12], mem_exp(m_held));
            chk("R10 pci", freq_code[11:0], pci_t[m_held % 16]);
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        #1000000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        running = 1'b1;
        tick(3);
        // R1 reset state
        chk("R1 rb", {rb_r1_b7, rb_r3_b6, rb_r4_b3, rb_r4_b1}, 15);
        chk("R1 mode/vdd", {mode_flag, cpu_vdd_25}, 3);
        chk("R1 sel", {sel_from_sw, sel_idx}, 15);

        por_n = 1'b1;
        tick(1);
        // R2 capture, R6 positions (fs = 0101)
        chk("R6 r1b7", rb_r1_b7, 1);
        chk("R6 r3b6", rb_r3_b6, 1);
        chk("R6 r4b3", rb_r4_b3, 0);
        chk("R6 r4b1", rb_r4_b1, 0);
        chk("R2 mode", mode_flag, 0);
        chk("R7 vdd 3.3V", cpu_vdd_25, 0);
        tick(2);
        chk("R4 hw idx", sel_idx, 5);
        chk("R10 mem row5", freq_code[23:12], 1336);

        // R3 pins move after capture
        pin_fs = 4'b1010; pin_mode = 1'b1; pin_vsel = 1'b1;
        tick(4);
        chk("R3 fs held", {rb_r4_b1, rb_r1_b7, rb_r4_b3, rb_r3_b6}, 5);
        chk("R3 mode held", mode_flag, 0);
        chk("R3 idx", sel_idx, 5);

        // R4/R5/R8 software select, index {1,011} = 11
        cfg_sel_byte = 8'h3C;
        tick(1);
        chk("R8 one edge", sel_idx, 5);
        tick(1);
        chk("R8 two edges", sel_idx, 11);
        chk("R4 src", sel_from_sw, 1);

        // R9 one-cycle glitch
        cfg_sel_byte = 8'h7C;
        tick(1);
        chk("R9 glitch", sel_idx, 11);
        cfg_sel_byte = 8'hBF;   // R5: bits 7,1,0 ignored, still index 11
        tick(3);
        chk("R9 after", sel_idx, 11);

        // R11 software row 2
        cfg_sel_byte = 8'h28;
        tick(2);
        chk("R11 sw idx", sel_idx, 2);
        chk("R11 sw mem", freq_code[23:12], 1249);

        // R5 sweep
        for (int i = 0; i < 16; i++) begin
            cfg_sel_byte = {1'b0, 3'(i), 1'b1, 1'(i >> 3), 2'b00};
            tick(3);
            chk("R5 sweep", sel_idx, i);
        end

        cfg_sel_byte = 8'h00;
        tick(2);
        chk("R4 back to hw", {sel_from_sw, sel_idx}, 5);

        // Second power-on with new straps
        pin_fs = 4'b0010; pin_mode = 1'b1; pin_vsel = 1'b1;
        por_n = 1'b0;
        tick(2);
        chk("R1 again", {sel_from_sw, sel_idx}, 15);
        por_n = 1'b1;
        tick(3);
        chk("R3 recapture", sel_idx, 2);
        chk("R11 hw mem", freq_code[23:12], 833);
        chk("R7 vdd 2.5V", cpu_vdd_25, 1);
        chk("R7 mode", mode_flag, 1);

        tick(2);
        running = 1'b0;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule